// File: doc/BRIEF.md
# Port Status Lamp Driver

This block turns the status of one Ethernet PHY port into four active-low indicator outputs. Two lamps show a good link and its speed (100 Mb/s or 10 Mb/s). A third lamp blinks while frames are received or sent. A fourth lamp is shared. It stays lit while the port runs in full duplex. In half duplex it blinks, at a faster rate than the activity lamp, while collisions occur.

Blink timing comes from a prescaler on the system clock. The prescaler yields a base tick, and each blinking lamp counts a whole number of ticks per half-period. A blink that has started runs for whole periods. A period with no event ends the blink, so a frame only one clock long still produces one full flash. When the link goes down, both blinking indications are cancelled. A mode input blanks all four lamps. All lamp outputs are registered.

Top module: `port_led_driver`

## Requirements
- R1: While reset is low, every lamp output is 1 (dark) at the next clock edge.
- R2: Lamps are active low (0 = lit). One cycle after `link_up_i`=1 and `speed_100_i`=1 are sampled, `led_link100_n_o` is 0 and `led_link10_n_o` is 1.
- R3: One cycle after `link_up_i`=1 and `speed_100_i`=0 are sampled, `led_link10_n_o` is 0 and `led_link100_n_o` is 1. The two link lamps are never lit together.
- R4: When `rx_active_i` or `tx_active_i` is sampled high with the link up and the activity blink idle, `led_act_n_o` is 0 two cycles later. It stays 0 for exactly ACT_HALF_TICKS*PRESCALE_DIV cycles and then stays 1 for the same number of cycles.
- R5: A blink period with no event during it ends the blink, and the lamp stays dark. An event during a period adds one more full period, which starts lit. A one-cycle event therefore gives exactly one flash.
- R6: In half duplex, a sampled `collision_i` blinks `led_dup_col_n_o` in the same way, with a half-period of COL_HALF_TICKS*PRESCALE_DIV cycles.
- R7: With the link up and `full_duplex_i`=1, `led_dup_col_n_o` is 0 from the next cycle onward, and `collision_i` has no effect on it. When `full_duplex_i` drops with no collision blink running, the lamp is 1 on the next cycle.
- R8: When `link_up_i` is sampled low, all four lamps are 1 on the next cycle and any running blink is cancelled. Events seen while the link is down are not remembered.
- R9: When `mode_i`=1 is sampled, all four lamps are 1 on the next cycle. When `mode_i` returns to 0, the normal display is back one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up_i | input | 1 | Link is good |
| speed_100_i | input | 1 | 1 = 100 Mb/s link, 0 = 10 Mb/s |
| full_duplex_i | input | 1 | 1 = full duplex |
| rx_active_i | input | 1 | Port is receiving |
| tx_active_i | input | 1 | Port is transmitting |
| collision_i | input | 1 | Collision in progress |
| mode_i | input | 1 | 1 = all lamps blanked |
| led_link100_n_o | output | 1 | 100 Mb/s link lamp, active low |
| led_link10_n_o | output | 1 | 10 Mb/s link lamp, active low |
| led_act_n_o | output | 1 | Activity lamp, active low |
| led_dup_col_n_o | output | 1 | Full duplex / collision lamp, active low |

## Verification
The bench builds the block with PRESCALE_DIV=3, ACT_HALF_TICKS=4 and COL_HALF_TICKS=2. This gives half-periods of 12 and 6 cycles, in place of millions of cycles at a real clock rate. With these values a whole activity flash fits in a few dozen cycles, and so does a retriggered second period. The bench can then check the exact cycle where each half-period starts and ends, and the cycle where each blink stops. The short collision half-period also lets the bench hold collisions across several blink periods in full duplex, to show that the shared lamp stays steady.

// File: rtl/led_pkg.sv
// Shared types for the port status lamp driver.
// Assumes: lamp vectors are carried as logic level "lit" (1 = lamp on)
// inside the block and inverted only at the output register.
package led_pkg;

    // One bit per lamp; 1 means the lamp should be on.
    typedef struct packed {
        logic link100;
        logic link10;
        logic act;
        logic dupcol;
    } lamp_vec_t;

    localparam lamp_vec_t LAMPS_OFF = '{link100: 1'b0, link10: 1'b0, act: 1'b0, dupcol: 1'b0};

endpackage

// File: rtl/led_tick_div.sv
// Clock prescaler producing one-cycle ticks every DIV clocks while run_i is high.
// Assumes: run_i low holds the count at zero, so the first tick after run_i
// rises appears exactly DIV cycles later.
module led_tick_div #(
    parameter int DIV = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_direct
            // Every running cycle is a tick.
            assign tick_o = run_i;
        end else begin : g_count
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            // Count clocks while running; wrap on the last count.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = run_i && (cnt_q == LAST);

            p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LAST);
        end
    endgenerate
endmodule

// File: rtl/led_blink_chan.sv
// One blinking indication. An event starts a blink in its lit half. Blinking
// goes on in whole periods (lit half, then dark half) while events keep arriving.
// A period with no event ends the blink at its close.
// Assumes: clr_i cancels everything at once; the half-period is HALF ticks of
// DIV clocks each.
module led_blink_chan #(
    parameter int DIV  = 25000,
    parameter int HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic evt_i,
    output logic lamp_o
);
    localparam int HW        = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF - 1);
    localparam int HALF_CYC  = DIV * HALF;

    logic          running_q;
    logic          lit_q;
    logic          seen_q;
    logic [HW-1:0] half_q;
    logic          tick;

    led_tick_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running_q && !clr_i),
        .tick_o (tick)
    );

    // Blink sequencer: start, half-period toggling, retrigger or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            running_q <= 1'b0;
            lit_q     <= 1'b0;
            seen_q    <= 1'b0;
            half_q    <= '0;
        end else if (!running_q) begin
            if (evt_i) begin
                running_q <= 1'b1;
                lit_q     <= 1'b1;
                seen_q    <= 1'b0;
                half_q    <= '0;
            end
        end else begin
            seen_q <= seen_q | evt_i;
            if (tick) begin
                if (half_q == HALF_LAST) begin
                    half_q <= '0;
                    if (lit_q) begin
                        lit_q <= 1'b0;
                    end else if (seen_q || evt_i) begin
                        lit_q  <= 1'b1;
                        seen_q <= 1'b0;
                    end else begin
                        running_q <= 1'b0;
                    end
                end else begin
                    half_q <= half_q + 1'b1;
                end
            end
        end
    end

    assign lamp_o = running_q && lit_q;

    // Length of the current lit stretch, for the half-period bound check.
    int lit_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !lamp_o) lit_len_q <= 0;
        else                   lit_len_q <= lit_len_q + 1;
    end

    p_clear_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !lamp_o);
    p_start_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_q && evt_i && !clr_i) |=> lamp_o);
    p_lit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lit_len_q <= HALF_CYC);
    p_half_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        half_q <= HALF_LAST);
endmodule

// File: rtl/port_led_driver.sv
// Status lamp driver for one Ethernet port: link speed lamps, a blinking
// activity lamp and a shared duplex/collision lamp, all active low and registered.
// Assumes: status inputs are synchronous to clk; half-periods are given in
// prescaler ticks of PRESCALE_DIV clocks.
module port_led_driver
    import led_pkg::*;
#(
    parameter int PRESCALE_DIV   = 25000,
    parameter int ACT_HALF_TICKS = 50,
    parameter int COL_HALF_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up_i,
    input  logic speed_100_i,
    input  logic full_duplex_i,
    input  logic rx_active_i,
    input  logic tx_active_i,
    input  logic collision_i,
    input  logic mode_i,
    output logic led_link100_n_o,
    output logic led_link10_n_o,
    output logic led_act_n_o,
    output logic led_dup_col_n_o
);
    logic      act_lamp;
    logic      col_lamp;
    lamp_vec_t want;
    lamp_vec_t lit_q;

    // Activity blinker: events gated by link, cancelled when link is lost.
    led_blink_chan #(.DIV(PRESCALE_DIV), .HALF(ACT_HALF_TICKS)) u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!link_up_i),
        .evt_i  (link_up_i && (rx_active_i || tx_active_i)),
        .lamp_o (act_lamp)
    );

    // Collision blinker: half duplex only; full duplex or link loss cancels it.
    led_blink_chan #(.DIV(PRESCALE_DIV), .HALF(COL_HALF_TICKS)) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!link_up_i || full_duplex_i),
        .evt_i  (link_up_i && !full_duplex_i && collision_i),
        .lamp_o (col_lamp)
    );

    // Lamp selection before blanking and output registering.
    always_comb begin
        want.link100 = link_up_i && speed_100_i;
        want.link10  = link_up_i && !speed_100_i;
        want.act     = link_up_i && act_lamp;
        want.dupcol  = link_up_i && (full_duplex_i || col_lamp);
    end

    // Output register: dark in reset or when blanked.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_i) lit_q <= LAMPS_OFF;
        else                  lit_q <= want;
    end

    assign led_link100_n_o = !lit_q.link100;
    assign led_link10_n_o  = !lit_q.link10;
    assign led_act_n_o     = !lit_q.act;
    assign led_dup_col_n_o = !lit_q.dupcol;

    p_reset_dark_r1: assert property (@(posedge clk)
        !rst_n |=> (led_link100_n_o && led_link10_n_o && led_act_n_o && led_dup_col_n_o));
    p_link_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!led_link100_n_o, !led_link10_n_o}));
    p_fdx_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up_i && full_duplex_i && !mode_i) |=> !led_dup_col_n_o);
    p_link_down_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up_i |=> (led_link100_n_o && led_link10_n_o && led_act_n_o && led_dup_col_n_o));
    p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |=> (led_link100_n_o && led_link10_n_o && led_act_n_o && led_dup_col_n_o));
endmodule

// File: tb/port_led_driver_tb.sv
module port_led_driver_tb;
    localparam int DIV = 3;
    localparam int AH  = 4;
    localparam int CH  = 2;
    localparam int H   = DIV * AH;
    localparam int HC  = DIV * CH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_up = 1'b0, spd100 = 1'b0, fdx = 1'b0;
    logic rx = 1'b0, tx = 1'b0, col = 1'b0, mode = 1'b0;
    logic l100, l10, lact, ldc;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    // Scoreboard queues: sample cycle, mask, expected vector {100,10,act,dupcol}.
    int         q_at[$];
    logic [3:0] q_mask[$];
    logic [3:0] q_val[$];
    string      q_tag[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    port_led_driver #(.PRESCALE_DIV(DIV), .ACT_HALF_TICKS(AH), .COL_HALF_TICKS(CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .speed_100_i(spd100),
        .full_duplex_i(fdx), .rx_active_i(rx), .tx_active_i(tx), .collision_i(col),
        .mode_i(mode), .led_link100_n_o(l100), .led_link10_n_o(l10),
        .led_act_n_o(lact), .led_dup_col_n_o(ldc)
    );

    task automatic expect_at(int at, logic [3:0] mask, logic [3:0] val, string tag);
        q_at.push_back(at);
        q_mask.push_back(mask);
        q_val.push_back(val);
        q_tag.push_back(tag);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare due expectations at the falling edge.
    always @(negedge clk) begin
        for (int i = q_at.size() - 1; i >= 0; i--) begin
            if (q_at[i] <= cyc) begin
                logic [3:0] act;
                act = {l100, l10, lact, ldc};
                checks++;
                if (q_at[i] < cyc || ((act & q_mask[i]) != (q_val[i] & q_mask[i]))) begin
                    errors++;
                    $display("FAIL %s at cycle %0d: actual=%b expected=%b mask=%b",
                             q_tag[i], q_at[i], act, q_val[i], q_mask[i]);
                end
                q_at.delete(i);
                q_mask.delete(i);
                q_val.delete(i);
                q_tag.delete(i);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        int t;
        // R1: reset state.
        step(1);
        expect_at(cyc + 1, 4'b1111, 4'b1111, "R1 reset dark");
        step(3);
        rst_n = 1'b1;
        step(2);

        // R2: 100M link lamp.
        t = cyc;
        link_up = 1'b1; spd100 = 1'b1;
        expect_at(t + 1, 4'b1111, 4'b0111, "R2 100M lit");
        step(3);

        // R3: 10M link lamp.
        t = cyc;
        spd100 = 1'b0;
        expect_at(t + 1, 4'b1100, 4'b1000, "R3 10M lit");
        step(3);

        // R4/R5: single-cycle receive gives exactly one flash.
        t = cyc;
        expect_at(t + 1,         4'b0010, 4'b0010, "R4 not yet lit");
        expect_at(t + 2,         4'b0010, 4'b0000, "R4 lit start");
        expect_at(t + H + 1,     4'b0010, 4'b0000, "R4 lit end");
        expect_at(t + H + 2,     4'b0010, 4'b0010, "R4 dark half");
        expect_at(t + 2 * H + 1, 4'b0010, 4'b0010, "R4 dark end");
        expect_at(t + 2 * H + 2, 4'b0010, 4'b0010, "R5 single flash stops");
        rx = 1'b1; step(1); rx = 1'b0;
        step(2 * H + 6);

        // R5: event in the dark half adds a second period.
        t = cyc;
        expect_at(t + 2 * H + 1, 4'b0010, 4'b0010, "R5 dark before retrigger");
        expect_at(t + 2 * H + 2, 4'b0010, 4'b0000, "R5 second period lit");
        expect_at(t + 3 * H + 1, 4'b0010, 4'b0000, "R5 second lit end");
        expect_at(t + 3 * H + 2, 4'b0010, 4'b0010, "R5 second dark");
        expect_at(t + 4 * H + 2, 4'b0010, 4'b0010, "R5 stops after quiet period");
        tx = 1'b1; step(1); tx = 1'b0;
        step(H + 2);
        tx = 1'b1; step(1); tx = 1'b0;
        step(3 * H + 6);

        // R6: collision blink in half duplex.
        t = cyc;
        expect_at(t + 1,          4'b0001, 4'b0001, "R6 not yet lit");
        expect_at(t + 2,          4'b0001, 4'b0000, "R6 lit start");
        expect_at(t + HC + 1,     4'b0001, 4'b0000, "R6 lit end");
        expect_at(t + HC + 2,     4'b0001, 4'b0001, "R6 dark half");
        expect_at(t + 2 * HC + 2, 4'b0001, 4'b0001, "R6 stopped");
        col = 1'b1; step(1); col = 1'b0;
        step(2 * HC + 6);

        // R7: full duplex steady, collision ignored.
        t = cyc;
        fdx = 1'b1;
        expect_at(t + 1,          4'b0001, 4'b0000, "R7 fdx lit");
        expect_at(t + 10,         4'b0001, 4'b0000, "R7 steady under collision");
        expect_at(t + 4 + 2 * HC + 2, 4'b0001, 4'b0000, "R7 steady later");
        step(4);
        col = 1'b1; step(3 * HC); col = 1'b0;
        step(2);
        t = cyc;
        fdx = 1'b0;
        expect_at(t + 1, 4'b0001, 4'b0001, "R7 off after fdx drops");
        expect_at(t + 4, 4'b0001, 4'b0001, "R7 no leftover blink");
        step(6);

        // R8: link loss cancels a running blink; events while down ignored.
        spd100 = 1'b1;
        step(2);
        t = cyc;
        expect_at(t + 3,  4'b1010, 4'b0000, "R8 blink running");
        expect_at(t + 5,  4'b1111, 4'b1111, "R8 all dark on link loss");
        expect_at(t + 8,  4'b1111, 4'b1111, "R8 still dark");
        expect_at(t + 14, 4'b1010, 4'b0010, "R8 no stored event");
        expect_at(t + 16, 4'b1010, 4'b0010, "R8 act stays dark");
        rx = 1'b1; step(1); rx = 1'b0;
        step(3);
        link_up = 1'b0;
        step(6);
        rx = 1'b1; step(1); rx = 1'b0;
        step(2);
        link_up = 1'b1;
        step(6);

        // R9: blanking.
        t = cyc;
        fdx = 1'b1;
        expect_at(t + 1, 4'b1001, 4'b0000, "R9 lamps on before blank");
        expect_at(t + 4, 4'b1111, 4'b1111, "R9 blanked");
        expect_at(t + 7, 4'b1111, 4'b0110, "R9 restored");
        step(3);
        mode = 1'b1;
        step(3);
        mode = 1'b0;
        step(4);

        if (q_at.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", q_at.size());
        end
        finish_run();
    end
endmodule